// File: doc/BRIEF.md
# Binary XNOR-Popcount Neuron

This block evaluates one neuron of a binarized network layer. Activations and weights are each one bit wide, with logic 1 standing for +1 and logic 0 for -1. The product of an activation and a weight is then the XNOR of the two bits. A word of `WORD_W` activations is compared against one stored weight word, and the matching positions are counted. These counts are summed over every word of an input vector. At the end of the vector the total is compared with a programmable threshold, and the result is a single activation bit for the next layer.

Weights are loaded one at a time as signed integers, and the block keeps only whether each one is positive. The input stream uses a valid/ready handshake. Each word carries a first-word flag, a last-word flag and a lane mask, so a short final word can leave its unused positions out of the count. Counting runs through a two-stage registered adder tree, and an accumulate-and-compare stage follows it. The result therefore has a fixed latency. While a vector is open or still inside the pipeline, writes to the weights and to the threshold are held off.

Top module: `bnn_xnor_neuron`

## Requirements
- R1: A weight write stores bit 1 when the signed value is greater than zero, and bit 0 when it is zero or negative (for example -128, -1 and 0 all store 0; 1 and 127 store 1). The bit goes to word `wgt_wr_word`, position `wgt_wr_lane`.
- R2: For each accepted word, the contribution is the number of positions `b` where `in_mask[b]` is 1 and `in_data[b]` equals weight bit `b` of the selected weight word.
- R3: A word accepted with `in_first`=1 starts a new sum from zero. Every later word adds its contribution to the running sum. The sum never wraps for vectors of up to `NUM_WORDS` full words.
- R4: A position whose `in_mask` bit is 0 adds nothing to the sum, whatever its data and weight are.
- R5: `out_bit` is 1 when the finished sum is greater than or equal to the threshold register, and 0 otherwise. Equality gives 1.
- R6: `out_valid` is high for exactly one cycle for each accepted word that has `in_last`=1. It rises on the third rising edge after the edge that accepted that word, and it is never high at any other time.
- R7: `cfg_ready` is 0 from the edge that accepts any word until three edges after the last accepted word. It is also 0 while a vector is open, meaning a first word has been taken and its last word has not. A weight or threshold write presented while `cfg_ready` is 0 has no effect.
- R8: `in_ready` is 0 only in a cycle where `cfg_ready` is 1 and a weight or threshold write is presented; the write is taken in that cycle and the word waits.
- R9: After reset every weight bit is 0, the threshold is 0, `out_valid` is 0, and both `cfg_ready` and `in_ready` are 1.
- R10: A word accepted with `in_first`=1 uses weight word 0. Each later word of the vector uses the next weight word, and the index wraps from `NUM_WORDS`-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Activation word offered |
| in_ready | output | 1 | Activation word can be taken this cycle |
| in_first | input | 1 | Word starts a new vector |
| in_last | input | 1 | Word ends the vector |
| in_data | input | WORD_W | Activation bits, 1 = +1, 0 = -1 |
| in_mask | input | WORD_W | Lanes that count toward the sum |
| wgt_wr_en | input | 1 | Weight write request |
| wgt_wr_word | input | $clog2(NUM_WORDS) | Weight word index |
| wgt_wr_lane | input | $clog2(WORD_W) | Bit position inside the word |
| wgt_wr_value | input | WGT_W | Signed integer weight |
| thr_wr_en | input | 1 | Threshold write request |
| thr_wr_value | input | ACC_W | New threshold |
| cfg_ready | output | 1 | Weight and threshold writes are accepted |
| out_valid | output | 1 | One-cycle result strobe |
| out_bit | output | 1 | Neuron activation |

## Verification
`in_ready` is combinational, so it is compared in the same cycle that its inputs are driven. The other outputs come from registers and are compared at the falling edge after each rising edge. The reference model records the cycle number at which each word is accepted. For a last word it queues the expected bit together with a due cycle three edges later. `out_valid` and `out_bit` are checked against the head of that queue in exactly that cycle, and `out_valid` must be low in every other cycle. `cfg_ready` is expected low until three edges have passed since the latest accepted word and no vector is open. Ignored writes are exposed through later results whose expected bits depend on the unchanged weights and threshold.

// File: rtl/bnn_pkg.sv
package bnn_pkg;

    // Control bits that travel with a word through the pipeline.
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } beat_flags_t;

    localparam beat_flags_t BEAT_IDLE = '{valid: 1'b0, first: 1'b0, last: 1'b0};

endpackage

// File: rtl/bnn_weight_store.sv
module bnn_weight_store #(
    parameter int WORD_W    = 64,
    parameter int NUM_WORDS = 16,
    parameter int WGT_W     = 8,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int LANE_W   = $clog2(WORD_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_word,
    input  logic [LANE_W-1:0]       wr_lane,
    input  logic signed [WGT_W-1:0] wr_value,
    input  logic [IDX_W-1:0]        rd_word,
    output logic [WORD_W-1:0]       rd_bits
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] mem_d, mem_q;
    logic                             sign_bit;

    // Positive means sign bit clear and not all zero.
    assign sign_bit = ~wr_value[WGT_W-1] & (|wr_value);

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (int'(wr_word) < NUM_WORDS)) begin
            mem_d[wr_word][wr_lane] = sign_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_bits = mem_q[rd_word];

    AST_ZERO_IS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_value == '0) |=> mem_q[$past(wr_word)][$past(wr_lane)] == 1'b0) // R1
        else $error("zero weight stored as +1");

endmodule

// File: rtl/bnn_popcount.sv
module bnn_popcount
    import bnn_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int GROUP_W = 8,
    localparam int CNT_W  = $clog2(WORD_W + 1),
    localparam int GROUPS = WORD_W / GROUP_W,
    localparam int GC_W   = $clog2(GROUP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_flags_t       in_flags,
    input  logic [WORD_W-1:0] in_bits,
    output beat_flags_t       cnt_flags,
    output logic [CNT_W-1:0]  cnt,
    output logic              busy
);

    typedef struct packed {
        beat_flags_t                  f1;
        logic [GROUPS-1:0][GC_W-1:0]  grp;
        beat_flags_t                  f2;
        logic [CNT_W-1:0]             sum;
    } pc_state_t;

    pc_state_t                   pc_d, pc_q;
    logic [GROUPS-1:0][GC_W-1:0] grp_cnt;

    // First tree level: one small counter per lane group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        always_comb begin
            grp_cnt[g] = '0;
            for (int i = 0; i < GROUP_W; i++) begin
                grp_cnt[g] = grp_cnt[g] + GC_W'(in_bits[g*GROUP_W + i]);
            end
        end
    end

    always_comb begin
        pc_d     = pc_q;
        pc_d.f1  = in_flags;
        pc_d.grp = grp_cnt;
        pc_d.f2  = pc_q.f1;
        pc_d.sum = '0;
        for (int g = 0; g < GROUPS; g++) begin
            pc_d.sum = pc_d.sum + CNT_W'(pc_q.grp[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            pc_q.f1 <= BEAT_IDLE;
            pc_q.f2 <= BEAT_IDLE;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign cnt_flags = pc_q.f2;
    assign cnt       = pc_q.sum;
    assign busy      = pc_q.f1.valid | pc_q.f2.valid;

    AST_PC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_flags.valid |-> ##2 cnt_flags.valid) // R6
        else $error("popcount latency broken");

    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_flags.valid |-> (int'(cnt) <= WORD_W)) // R2
        else $error("word count exceeds lane count");

endmodule

// File: rtl/bnn_accum.sv
module bnn_accum
    import bnn_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int ACC_W  = 16,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_flags_t       cnt_flags,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ACC_W-1:0]  thr,
    output logic              out_valid,
    output logic              out_bit
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ov;
        logic             ob;
    } acc_state_t;

    acc_state_t       acc_d, acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] total;

    always_comb begin
        acc_d = acc_q;
        base  = cnt_flags.first ? '0 : acc_q.acc;
        total = base + ACC_W'(cnt);
        acc_d.ov = cnt_flags.valid & cnt_flags.last;
        if (cnt_flags.valid) begin
            acc_d.acc = total;
        end
        if (cnt_flags.valid && cnt_flags.last) begin
            acc_d.ob = (total >= thr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign out_valid = acc_q.ov;
    assign out_bit   = acc_q.ob;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_flags.valid && !cnt_flags.first) |->
            ((ACC_W+1)'(acc_q.acc) + (ACC_W+1)'(cnt)) < (ACC_W+1)'(1 << ACC_W)) // R3
        else $error("accumulator overflow");

    AST_THR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_flags.valid |-> $stable(thr)) // R7
        else $error("threshold changed under a word in flight");

endmodule

// File: rtl/bnn_xnor_neuron.sv
module bnn_xnor_neuron
    import bnn_pkg::*;
#(
    parameter int WORD_W    = 64,
    parameter int NUM_WORDS = 16,
    parameter int WGT_W     = 8,
    parameter int ACC_W     = 16,
    parameter int GROUP_W   = 8,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int LANE_W   = $clog2(WORD_W),
    localparam int CNT_W    = $clog2(WORD_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic [WORD_W-1:0]       in_data,
    input  logic [WORD_W-1:0]       in_mask,
    input  logic                    wgt_wr_en,
    input  logic [IDX_W-1:0]        wgt_wr_word,
    input  logic [LANE_W-1:0]       wgt_wr_lane,
    input  logic signed [WGT_W-1:0] wgt_wr_value,
    input  logic                    thr_wr_en,
    input  logic [ACC_W-1:0]        thr_wr_value,
    output logic                    cfg_ready,
    output logic                    out_valid,
    output logic                    out_bit
);

    typedef struct packed {
        logic              open;
        logic [IDX_W-1:0]  idx;
        logic [ACC_W-1:0]  thr;
        beat_flags_t       s1;
        logic [WORD_W-1:0] s1_bits;
    } ctl_state_t;

    ctl_state_t        ctl_d, ctl_q;
    logic              accept;
    logic              cfg_req;
    logic              pc_busy;
    logic [IDX_W-1:0]  word_sel;
    logic [WORD_W-1:0] wgt_bits;
    beat_flags_t       cnt_flags;
    logic [CNT_W-1:0]  cnt;

    always_comb begin
        ctl_d     = ctl_q;
        cfg_ready = ~(ctl_q.open | ctl_q.s1.valid | pc_busy);
        cfg_req   = wgt_wr_en | thr_wr_en;
        in_ready  = ~(cfg_ready & cfg_req);
        accept    = in_valid & in_ready;
        word_sel  = in_first ? '0 : ctl_q.idx;

        ctl_d.s1.valid = accept;
        ctl_d.s1.first = in_first;
        ctl_d.s1.last  = in_last;
        ctl_d.s1_bits  = ~(in_data ^ wgt_bits) & in_mask;

        if (accept) begin
            ctl_d.open = ~in_last;
            ctl_d.idx  = (word_sel == IDX_W'(NUM_WORDS - 1)) ? '0 : word_sel + 1'b1;
        end
        if (cfg_ready && thr_wr_en) begin
            ctl_d.thr = thr_wr_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.s1 <= BEAT_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bnn_weight_store #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .WGT_W     (WGT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_ready & wgt_wr_en),
        .wr_word  (wgt_wr_word),
        .wr_lane  (wgt_wr_lane),
        .wr_value (wgt_wr_value),
        .rd_word  (word_sel),
        .rd_bits  (wgt_bits)
    );

    bnn_popcount #(
        .WORD_W  (WORD_W),
        .GROUP_W (GROUP_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_flags  (ctl_q.s1),
        .in_bits   (ctl_q.s1_bits),
        .cnt_flags (cnt_flags),
        .cnt       (cnt),
        .busy      (pc_busy)
    );

    bnn_accum #(
        .WORD_W (WORD_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_flags (cnt_flags),
        .cnt       (cnt),
        .thr       (ctl_q.thr),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |=> ctl_q.thr == $past(ctl_q.thr)) // R7
        else $error("threshold written while busy");

    AST_OPEN_BLOCKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_last) |=> !cfg_ready) // R7
        else $error("configuration open during a vector");

endmodule

// File: tb/tb_bnn_xnor_neuron.sv
module tb_bnn_xnor_neuron;

    localparam int WORD_W = 64;
    localparam int NUM_WORDS = 16;
    localparam int WGT_W = 8;
    localparam int ACC_W = 16;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_first = 0, in_last = 0;
    logic [WORD_W-1:0] in_data = '0, in_mask = '0;
    logic wgt_wr_en = 0;
    logic [3:0] wgt_wr_word = '0;
    logic [5:0] wgt_wr_lane = '0;
    logic signed [WGT_W-1:0] wgt_wr_value = '0;
    logic thr_wr_en = 0;
    logic [ACC_W-1:0] thr_wr_value = '0;
    logic in_ready, cfg_ready, out_valid, out_bit;

    always #2 clk = ~clk;

    bnn_xnor_neuron dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_last(in_last), .in_data(in_data), .in_mask(in_mask),
        .wgt_wr_en(wgt_wr_en), .wgt_wr_word(wgt_wr_word), .wgt_wr_lane(wgt_wr_lane),
        .wgt_wr_value(wgt_wr_value), .thr_wr_en(thr_wr_en), .thr_wr_value(thr_wr_value),
        .cfg_ready(cfg_ready), .out_valid(out_valid), .out_bit(out_bit)
    );

    // Behavioural reference model
    bit m_w [NUM_WORDS*WORD_W];
    int m_thr, m_acc, m_idx, last_acc, cyc, m_last_cnt;
    bit m_open, m_cfg_rdy, exp_ov, exp_ob;
    int due_q[$];
    bit bit_q[$];
    int errors = 0, checks = 0;
    string cur_req = "R2";
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_w[i]) m_w[i] = 0;
            m_thr = 0; m_acc = 0; m_idx = 0; m_open = 0; last_acc = -100;
            m_cfg_rdy = 1; exp_ov = 0; exp_ob = 0; cyc = 0;
            due_q.delete(); bit_q.delete();
        end else begin
            bit cfg_ok, in_ok;
            cyc++;
            cfg_ok = m_cfg_rdy;
            in_ok = !(cfg_ok && (wgt_wr_en || thr_wr_en));
            if (cfg_ok && wgt_wr_en) m_w[int'(wgt_wr_word)*WORD_W + int'(wgt_wr_lane)] = (wgt_wr_value > 0);
            if (cfg_ok && thr_wr_en) m_thr = int'(thr_wr_value);
            if (in_valid && in_ok) begin
                int c;
                if (in_first) begin m_acc = 0; m_idx = 0; end
                c = 0;
                for (int b = 0; b < WORD_W; b++)
                    if (in_mask[b] && (in_data[b] == m_w[m_idx*WORD_W + b])) c++;
                m_acc += c;
                m_idx = (m_idx + 1) % NUM_WORDS;
                m_open = !in_last;
                last_acc = cyc;
                if (in_last) begin
                    due_q.push_back(cyc + LAT);
                    bit_q.push_back(m_acc >= m_thr);
                    m_last_cnt = m_acc;
                end
            end
            m_cfg_rdy = !m_open && (cyc - last_acc >= LAT);
            exp_ov = 0;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                exp_ov = 1; exp_ob = bit_q[0];
                void'(due_q.pop_front()); void'(bit_q.pop_front());
            end
        end
    end

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    // One clock: combinational ready checked right after driving, registered outputs at the falling edge.
    task automatic tick();
        #1;
        check("R8", "in_ready", int'(in_ready), int'(!(m_cfg_rdy && (wgt_wr_en || thr_wr_en))));
        @(negedge clk);
        check("R7", "cfg_ready", int'(cfg_ready), int'(m_cfg_rdy));
        check("R6", "out_valid", int'(out_valid), int'(exp_ov));
        if (exp_ov) check(cur_req, "out_bit", int'(out_bit), int'(exp_ob));
    endtask

    task automatic idle(int n);
        in_valid = 0; wgt_wr_en = 0; thr_wr_en = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic int unsigned xs();
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
        return seed;
    endfunction

    task automatic wr_w(int word, int lane, int val);
        wgt_wr_en = 1; wgt_wr_word = 4'(word); wgt_wr_lane = 6'(lane); wgt_wr_value = 8'(val);
        tick(); wgt_wr_en = 0;
    endtask

    task automatic wr_thr(int v);
        thr_wr_en = 1; thr_wr_value = 16'(v); tick(); thr_wr_en = 0;
    endtask

    logic [WORD_W-1:0] vd [32];
    logic [WORD_W-1:0] vm [32];

    task automatic gen_vec(int n);
        for (int i = 0; i < n; i++) begin vd[i] = {xs(), xs()}; vm[i] = '1; end
    endtask

    task automatic send(int i, bit f, bit l);
        in_valid = 1; in_first = f; in_last = l; in_data = vd[i]; in_mask = vm[i];
        tick(); in_valid = 0;
    endtask

    task automatic run_vec(int n);
        for (int i = 0; i < n; i++) send(i, i == 0, i == n - 1);
        idle(LAT + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired (cycle %0d)", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state at the ports
        check("R9", "out_valid after reset", int'(out_valid), 0);
        check("R9", "cfg_ready after reset", int'(cfg_ready), 1);
        check("R9", "in_ready after reset", int'(in_ready), 1);
        cur_req = "R9";
        vd[0] = '0; vm[0] = '1; wr_thr(64); run_vec(1);   // all weights -1: 64 matches
        vd[0] = '1; wr_thr(1); run_vec(1);                // no matches
        // R1: sign reduction of written weights
        cur_req = "R1";
        for (int w = 0; w < 4; w++)
            for (int l = 0; l < WORD_W; l++) wr_w(w, l, int'($signed(8'(xs()))));
        wr_w(0, 0, 0); wr_w(0, 1, 1); wr_w(0, 2, -1); wr_w(0, 3, -128); wr_w(0, 4, 127);
        wr_thr(1);
        for (int l = 0; l < 5; l++) begin
            vd[0] = '1; vm[0] = 64'(1) << l; run_vec(1);
        end
        // R2: XNOR count over several data patterns
        cur_req = "R2";
        wr_thr(128);
        gen_vec(4); run_vec(4);
        for (int i = 0; i < 4; i++) vd[i] = '0;
        run_vec(4);
        for (int i = 0; i < 4; i++) vd[i] = '1;
        run_vec(4);
        for (int i = 0; i < 4; i++) vd[i] = {32{2'b10}};
        run_vec(4);
        // R5: threshold boundary on a replayed vector
        cur_req = "R5";
        gen_vec(4); run_vec(4);
        begin
            int t = m_last_cnt;
            wr_thr(t); run_vec(4);
            wr_thr(t + 1); run_vec(4);
            wr_thr(t - 1); run_vec(4);
        end
        // R4: masked lanes never count
        cur_req = "R4";
        gen_vec(3); vm[2] = 64'h0000_0000_00FF_FFFF;
        run_vec(3);
        wr_thr(m_last_cnt); run_vec(3);
        vm[1] = '0; run_vec(3);
        // R3: back-to-back vectors and gaps inside a vector
        cur_req = "R3";
        wr_thr(40);
        for (int k = 0; k < 6; k++) begin
            vd[k] = {xs(), xs()}; vm[k] = '1;
        end
        for (int k = 0; k < 6; k++) send(k, 1, 1);
        send(0, 1, 0); idle(2); send(1, 0, 0); idle(1); send(2, 0, 1);
        send(3, 1, 0); send(4, 0, 1);
        idle(LAT + 1);
        // R10: word index wraps past the last weight word
        cur_req = "R10";
        wr_thr(576);
        gen_vec(18); run_vec(18);
        wr_thr(m_last_cnt); run_vec(18);
        // R7: writes while a vector is open or draining are ignored
        cur_req = "R7";
        wr_thr(200);
        gen_vec(2);
        send(0, 1, 0);
        thr_wr_en = 1; thr_wr_value = '0; wgt_wr_en = 1; wgt_wr_word = '0; wgt_wr_lane = '0;
        wgt_wr_value = 8'sd100;
        tick(); thr_wr_en = 0; wgt_wr_en = 0;
        send(1, 0, 1);
        thr_wr_en = 1; tick(); thr_wr_en = 0;
        idle(LAT + 1);
        wr_thr(1); vd[0] = '1; vm[0] = 64'h1; run_vec(1);
        // R8: a write in an idle cycle takes priority over a word
        cur_req = "R8";
        vd[0] = {xs(), xs()}; vm[0] = '1;
        in_valid = 1; in_first = 1; in_last = 1; in_data = vd[0]; in_mask = vm[0];
        thr_wr_en = 1; thr_wr_value = 16'd30;
        tick();
        thr_wr_en = 0;
        tick();
        idle(LAT + 2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule